// File: doc/BRIEF.md
# Fine/Coarse Hardware Thread Issue Selector

This block decides, every clock, which of several hardware threads owns the issue slot of a shared pipeline. Each thread reports whether it can issue this cycle. A thread that is stalled reports that it cannot. The thread currently owning the pipeline can also flag an expensive stall, such as a miss in the outer cache level. The selector drives the chosen thread number, a flag that says the slot is really used, and a flag that marks a change of owner.

The selector supports two policies, picked by one mode input. In the interleaved policy, ownership rotates every cycle in circular order and passes over threads that cannot issue. In the blocked policy, one thread keeps the pipeline until it reports an expensive stall. The selector then hands the pipeline to the next thread that can issue. The refill of the pipeline after such a handover is modelled as a fixed number of dead issue cycles.

Top module: `thread_issue_sel`

## Requirements
- R1: After reset the circular search pointer is at thread 0, so the first interleaved issue with all threads able to issue selects thread 0 without a switch flag.
- R2: In interleaved mode (`coarse_mode`=0) with every thread able, the issued thread advances by one each cycle and wraps from NUM_THR-1 to 0.
- R3: In interleaved mode the search begins at the thread after the last one issued and passes over every thread whose `thr_ready` bit is 0.
- R4: When no `thr_ready` bit is set, `issue_vld` is 0 and the pointer is kept, so the next issue continues from the thread after the last issued one.
- R5: In interleaved mode `thr_switch` is 1 exactly when a thread issues whose number differs from the previously issued thread; the previous thread is 0 after reset.
- R6: In blocked mode (`coarse_mode`=1) the current thread issues every cycle that its `thr_ready` bit is 1 and `long_stall` is 0. If its `thr_ready` bit is 0, `issue_vld` is 0 and ownership is kept, whatever the other threads report.
- R7: In blocked mode, when `long_stall` is 1 and another thread can issue, `thr_switch` pulses that cycle. Ownership passes to the first able thread after the current one in circular order. `issue_vld` stays 0 for BUBBLES cycles counted from the switch cycle, and `long_stall` is ignored during those cycles.
- R8: In blocked mode, when `long_stall` is 1 and no other thread can issue, ownership is kept, no switch flag and no dead cycles follow, and only that cycle has `issue_vld` at 0.
- R9: In interleaved mode `long_stall` has no effect on the choice; a change to interleaved mode abandons any remaining dead cycles.
- R10: Whenever `issue_vld` is 1, the `thr_ready` bit of `issue_tid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_mode | input | 1 | 0 = interleave every cycle, 1 = keep thread until expensive stall |
| thr_ready | input | NUM_THR | Bit t set when thread t can issue this cycle |
| long_stall | input | 1 | Current owner reports an expensive stall (blocked mode only) |
| issue_tid | output | $clog2(NUM_THR) | Thread owning the issue slot |
| issue_vld | output | 1 | Issue slot is used this cycle |
| thr_switch | output | 1 | Change of owning thread this cycle |

## Verification
The interleaved policy is driven with all threads able, which shows the plain rotation and wrap. Sparse ready masks show that unable threads are passed over. An all-stalled gap shows that the pointer is kept. A single able thread shows the switch flag staying low. The blocked policy is driven with a steady owner, a short stall of the owner, an expensive stall with others able, and an expensive stall with no other thread able. These separate the handover with its dead cycles from the plain hold. A mode change in the middle of the dead cycles and `long_stall` pulses in interleaved mode show that each input only counts under its own policy.

// File: rtl/thread_issue_sel_pkg.sv
package thread_issue_sel_pkg;

  // increment a thread number modulo n
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/rr_find.sv
module rr_find #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] idx
);

  logic [IW:0] pos;

  // walk from the farthest offset down so the nearest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = start;
    pos   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      pos = {1'b0, start} + (IW + 1)'(k);
      if (pos >= (IW + 1)'(N)) pos = pos - (IW + 1)'(N);
      if (mask[pos[IW-1:0]]) begin
        found = 1'b1;
        idx   = pos[IW-1:0];
      end
    end
  end

endmodule

// File: rtl/bubble_ctr.sv
module bubble_ctr #(
  parameter int BUBBLES = 3,
  localparam int CW = (BUBBLES > 1) ? $clog2(BUBBLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  output logic busy
);

  generate
    if (BUBBLES > 1) begin : g_cnt
      logic [CW-1:0] cnt_q, cnt_d;
      logic          cnt_en;

      always_comb begin
        cnt_en = 1'b0;
        cnt_d  = cnt_q;
        if (clr) begin
          cnt_en = (cnt_q != '0);
          cnt_d  = '0;
        end else if (load) begin
          cnt_en = 1'b1;
          cnt_d  = CW'(BUBBLES - 1);
        end else if (cnt_q != '0) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign busy = (cnt_q != '0);

      // R7: a new handover is never requested while dead cycles remain
      p_load_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);
    end else begin : g_none
      assign busy = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/thread_issue_sel.sv
module thread_issue_sel #(
  parameter int NUM_THR = 4,
  parameter int BUBBLES = 3,
  localparam int TW = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               coarse_mode,
  input  logic [NUM_THR-1:0] thr_ready,
  input  logic               long_stall,
  output logic [TW-1:0]      issue_tid,
  output logic               issue_vld,
  output logic               thr_switch
);
  import thread_issue_sel_pkg::*;

  logic [TW-1:0]      ptr_q, ptr_d, prev_q, prev_d;
  logic               ptr_en, prev_en;
  logic [NUM_THR-1:0] own_hot, srch_mask;
  logic               srch_found, bub_load, bub_busy;
  logic [TW-1:0]      srch_idx;

  always_comb begin
    own_hot = '0;
    own_hot[ptr_q] = 1'b1;
  end

  // blocked mode hunts for a thread other than the owner
  assign srch_mask = coarse_mode ? (thr_ready & ~own_hot) : thr_ready;

  rr_find #(.N(NUM_THR)) u_find (
    .mask  (srch_mask),
    .start (ptr_q),
    .found (srch_found),
    .idx   (srch_idx)
  );

  bubble_ctr #(.BUBBLES(BUBBLES)) u_bub (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!coarse_mode),
    .load  (bub_load),
    .busy  (bub_busy)
  );

  always_comb begin
    issue_tid  = ptr_q;
    issue_vld  = 1'b0;
    thr_switch = 1'b0;
    bub_load   = 1'b0;
    ptr_en     = 1'b0;
    ptr_d      = ptr_q;
    prev_en    = 1'b0;
    prev_d     = prev_q;
    if (!coarse_mode) begin
      if (srch_found) begin
        issue_tid  = srch_idx;
        issue_vld  = 1'b1;
        thr_switch = (srch_idx != prev_q);
        ptr_en     = 1'b1;
        ptr_d      = TW'(wrap_inc(int'(srch_idx), NUM_THR));
        prev_en    = 1'b1;
        prev_d     = srch_idx;
      end
    end else if (!bub_busy) begin
      if (long_stall) begin
        if (srch_found) begin
          thr_switch = 1'b1;
          bub_load   = 1'b1;
          ptr_en     = 1'b1;
          ptr_d      = srch_idx;
        end
      end else if (thr_ready[ptr_q]) begin
        issue_vld = 1'b1;
        prev_en   = 1'b1;
        prev_d    = ptr_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      prev_q <= '0;
    end else begin
      if (ptr_en)  ptr_q  <= ptr_d;
      if (prev_en) prev_q <= prev_d;
    end
  end

  // R10: only an able thread may use the slot
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> thr_ready[issue_tid]);

  // R7: dead cycles after a handover carry no issue and no new handover
  p_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_mode && bub_busy) |-> (!issue_vld && !thr_switch));

  // R6: back-to-back blocked issues come from the same owner
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_mode && $past(coarse_mode) && $past(issue_vld) && issue_vld)
      |-> (issue_tid == $past(issue_tid)));

  // R8: an expensive stall never issues in the cycle it is reported
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_mode && long_stall) |-> !issue_vld);

  // R5: interleaved switch flag only accompanies a real issue
  p_fine_sw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!coarse_mode && thr_switch) |-> issue_vld);

  // R4: with nothing able the pointer does not move
  p_idle_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_ready == '0) |=> $stable(ptr_q));

endmodule

// File: tb/thread_issue_sel_bench.sv
module thread_issue_sel_bench;
  localparam int T  = 4;
  localparam int B  = 3;
  localparam int TW = $clog2(T);

  typedef struct {
    bit    vld;
    int    tid;
    bit    sw;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          coarse_mode;
  logic [T-1:0]  thr_ready;
  logic          long_stall;
  logic [TW-1:0] issue_tid;
  logic          issue_vld;
  logic          thr_switch;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  exp_t sb[$];

  // bench reference state, kept from the requirements
  int m_ptr = 0, m_prev = 0, m_dead = 0;

  always #10 clk = ~clk;

  thread_issue_sel #(.NUM_THR(T), .BUBBLES(B)) u_thread_issue_sel (
    .clk(clk), .rst_n(rst_n), .coarse_mode(coarse_mode),
    .thr_ready(thr_ready), .long_stall(long_stall),
    .issue_tid(issue_tid), .issue_vld(issue_vld), .thr_switch(thr_switch)
  );

  function automatic int first_able(input logic [T-1:0] m, input int from, input int skip);
    for (int k = 0; k < T; k++) begin
      int p = (from + k) % T;
      if (m[p] && p != skip) return p;
    end
    return -1;
  endfunction

  task automatic drive(input bit cm, input logic [T-1:0] rdy, input bit ls, input string tag);
    exp_t e;
    int f;
    @(negedge clk);
    coarse_mode = cm; thr_ready = rdy; long_stall = ls;
    e.vld = 0; e.tid = 0; e.sw = 0; e.tag = tag;
    if (!cm) begin
      m_dead = 0;
      f = first_able(rdy, m_ptr, -1);
      if (f >= 0) begin
        e.vld = 1; e.tid = f; e.sw = (f != m_prev);
        m_prev = f; m_ptr = (f + 1) % T;
      end
    end else if (m_dead > 0) begin
      m_dead--;
    end else if (ls) begin
      f = first_able(rdy, m_ptr, m_ptr);
      if (f >= 0) begin
        e.sw = 1; m_ptr = f; m_dead = B - 1;
      end
    end else if (rdy[m_ptr]) begin
      e.vld = 1; e.tid = m_ptr; m_prev = m_ptr;
    end
    sb.push_back(e);
  endtask

  // monitor: compare a quarter period after the inputs settle
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (issue_vld !== e.vld || thr_switch !== e.sw || (e.vld && int'(issue_tid) != e.tid)) begin
          bad++;
          $display("FAIL %s: got vld=%0b tid=%0d sw=%0b, expected vld=%0b tid=%0d sw=%0b",
                   e.tag, issue_vld, issue_tid, thr_switch, e.vld, e.tid, e.sw);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; coarse_mode = 1'b0; thr_ready = '0; long_stall = 1'b0;
    repeat (3) @(negedge clk);
    total++;
    if (issue_vld !== 1'b0 || thr_switch !== 1'b0) begin
      bad++;
      $display("FAIL R1: got vld=%0b sw=%0b in reset, expected 0 0", issue_vld, thr_switch);
    end
    rst_n = 1'b1;
    // R1 then R2: plain rotation and wrap
    drive(0, 4'b1111, 0, "R1");
    repeat (4) drive(0, 4'b1111, 0, "R2");
    // R3: sparse masks
    repeat (3) drive(0, 4'b0101, 0, "R3");
    drive(0, 4'b1010, 0, "R3");
    // R4: nothing able, then resume from after last issued
    repeat (2) drive(0, 4'b0000, 0, "R4");
    drive(0, 4'b1111, 0, "R4");
    // R5: single able thread gives no repeated switch
    repeat (2) drive(0, 4'b0001, 0, "R5");
    // R9: expensive stall ignored while interleaving
    repeat (2) drive(0, 4'b1111, 1, "R9");
    // R6: blocked owner holds, short stall keeps ownership
    repeat (3) drive(1, 4'b1111, 0, "R6");
    drive(1, 4'b0111, 0, "R6");
    drive(1, 4'b1110, 0, "R6");
    drive(1, 4'b1111, 0, "R6");
    // R7: handover with dead cycles, stall ignored during them
    drive(1, 4'b1111, 1, "R7");
    repeat (B - 1) drive(1, 4'b1111, 1, "R7");
    repeat (2) drive(1, 4'b1111, 0, "R7");
    // R8: expensive stall with nobody else able
    drive(1, 4'b0001 << m_ptr, 1, "R8");
    drive(1, 4'b0001 << m_ptr, 0, "R8");
    // R7 handover then R9 mode change inside the dead cycles
    drive(1, 4'b0101 | (4'b0001 << m_ptr), 1, "R7");
    drive(0, 4'b1111, 0, "R9");
    drive(0, 4'b1111, 0, "R2");
    drive(0, 4'b1111, 0, "R2");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule